// File: doc/BRIEF.md
# Selectable 2-bit Logic/Add Accumulator

This block is a small sequential function unit. It combines a 2-bit primary operand with a 2-bit secondary operand and returns a 3-bit result. A 2-bit select code picks the operation: invert, AND, OR or unsigned add. The invert operation uses only the secondary operand.

The secondary operand comes from one of two places. When the load control is high, it comes from external pins. When load is low, it comes from a feedback register that holds the low two result bits of the previous clock cycle. Holding load low therefore chains several operations over consecutive cycles, and each step works on the output of the step before it. Raising load at any step injects a new value.

The result is combinational and follows the selected operand within the same cycle. The feedback register loads on every rising clock edge, and a synchronous reset clears it.

Top module: `fsa_accum`

## Requirements
- R1: With select 2'b11, result bits [1:0] equal the bitwise inverse of the secondary operand, and the primary operand has no effect on them.
- R2: With select 2'b10, result bits [1:0] equal the primary operand ANDed bitwise with the secondary operand.
- R3: With select 2'b01, result bits [1:0] equal the primary operand ORed bitwise with the secondary operand.
- R4: With select 2'b00, the 3-bit result equals the unsigned sum of the primary and secondary operands, with bit 2 holding the carry. Bit 2 is unspecified for all other selects.
- R5: With load high, the secondary operand is the value on the external operand pins in that same cycle.
- R6: With load low, the secondary operand is result bits [1:0] as they stood just before the most recent rising clock edge. Bit 1 feeds operand bit 1 and bit 0 feeds operand bit 0. The register captures the result on every edge, whatever the level of load.
- R7: A synchronous active-high reset clears the feedback register to 2'b00 on the rising edge where reset is sampled high. Reset does not change the combinational path.
- R8: The result reflects changes to select, operands and load within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the feedback register |
| load | input | 1 | 1: secondary operand from pins; 0: from feedback register |
| op_sel | input | 2 | Operation select: 00 add, 01 OR, 10 AND, 11 invert |
| opa | input | 2 | Primary operand |
| opc | input | 2 | External secondary operand |
| res | output | 3 | Result; bit 2 is the carry for add, bits [1:0] feed back |

## Verification
Two events can land on the same edge: the feedback capture of a chained step and a synchronous reset. The bench raises reset while a load-low chain is producing a non-zero result. The next cycle is then judged with load low and the invert select. The expected value is the inverse of 2'b00, not the inverse of the result that was on the pins before the edge. Load and feedback also overlap: the bench injects a value with load high inside a chain and checks that the following chained step uses that step's result.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    localparam int OPND_W = 2;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_OR  = 2'b01,
        OP_AND = 2'b10,
        OP_INV = 2'b11
    } op_e;

    function automatic op_e to_op(input logic [1:0] code);
        return op_e'(code);
    endfunction
endpackage

// File: rtl/fsa_opnd_mux.sv
module fsa_opnd_mux #(
    parameter int W = fsa_pkg::OPND_W
) (
    input  logic         load,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] fb_val,
    output logic [W-1:0] opnd
);
    always_comb begin
        if (load) opnd = ext_val;
        else      opnd = fb_val;
    end
endmodule

// File: rtl/fsa_func_unit.sv
module fsa_func_unit #(
    parameter int W = fsa_pkg::OPND_W,
    localparam int RW = W + 1
) (
    input  fsa_pkg::op_e  op,
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    output logic [RW-1:0] r
);
    import fsa_pkg::*;

    always_comb begin
        unique case (op)
            OP_INV:  r = {1'b0, ~y};
            OP_AND:  r = {1'b0, x & y};
            OP_OR:   r = {1'b0, x | y};
            default: r = {1'b0, x} + {1'b0, y};
        endcase
    end
endmodule

// File: rtl/fsa_fb_reg.sv
module fsa_fb_reg #(
    parameter int W = fsa_pkg::OPND_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R7: reset clears the held value
    p_reset_clear_r7: assert property (@(posedge clk) rst |=> (q == '0));
    // R6: every non-reset edge captures the presented result
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/fsa_accum.sv
module fsa_accum #(
    parameter int W = fsa_pkg::OPND_W,
    localparam int RW = W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [1:0]    op_sel,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opc,
    output logic [RW-1:0] res
);
    import fsa_pkg::*;

    op_e          op;
    logic [W-1:0] fb_q;
    logic [W-1:0] opnd;

    assign op = to_op(op_sel);

    fsa_opnd_mux #(.W(W)) u_mux (
        .load    (load),
        .ext_val (opc),
        .fb_val  (fb_q),
        .opnd    (opnd)
    );

    fsa_func_unit #(.W(W)) u_fu (
        .op (op),
        .x  (opa),
        .y  (opnd),
        .r  (res)
    );

    fsa_fb_reg #(.W(W)) u_fb (
        .clk (clk),
        .rst (rst),
        .d   (res[W-1:0]),
        .q   (fb_q)
    );

    // set once an edge has passed without reset
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_inv_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INV && load) |-> (res[W-1:0] == ~opc));
    p_and_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_AND && load) |-> (res[W-1:0] == (opa & opc)));
    p_or_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OR && load) |-> (res[W-1:0] == (opa | opc)));
    p_add_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && load) |-> (res == ({1'b0, opa} + {1'b0, opc})));
    p_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !load && op == OP_INV) |-> (res[W-1:0] == ~$past(res[W-1:0])));
endmodule

// File: tb/tb_fsa_accum.sv
module tb_fsa_accum;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b1;
    logic [1:0] op_sel = 2'b00;
    logic [1:0] opa = 2'b00;
    logic [1:0] opc = 2'b00;
    logic [2:0] res;

    int checks = 0;
    int errors = 0;
    logic [1:0] fb_m = 2'b00;
    bit done = 0;

    always #5 clk = ~clk;

    fsa_accum dut (
        .clk(clk), .rst(rst), .load(load), .op_sel(op_sel),
        .opa(opa), .opc(opc), .res(res)
    );

    function automatic logic [2:0] model(input logic [1:0] s, input logic [1:0] x,
                                         input logic [1:0] y);
        case (s)
            2'b11:   return {1'b0, ~y};
            2'b10:   return {1'b0, x & y};
            2'b01:   return {1'b0, x | y};
            default: return 3'(x) + 3'(y);
        endcase
    endfunction

    // one step: drive after falling edge, sample mid-low phase, model the edge
    task automatic step(input logic [1:0] s, input logic [1:0] x, input logic [1:0] y,
                        input logic ld, input logic r, input string tag);
        logic [1:0] o;
        logic [2:0] e;
        @(negedge clk);
        op_sel = s; opa = x; opc = y; load = ld; rst = r;
        #2;
        o = ld ? y : fb_m;
        e = model(s, x, o);
        checks++;
        if (res[1:0] !== e[1:0]) begin
            errors++;
            $display("FAIL %s: sel=%b a=%b c=%b load=%b res[1:0]=%b expected %b",
                     tag, s, x, y, ld, res[1:0], e[1:0]);
        end
        if (s == 2'b00) begin
            checks++;
            if (res[2] !== e[2]) begin
                errors++;
                $display("FAIL %s carry: a=%b c=%b E=%b expected %b", tag, x, o, res[2], e[2]);
            end
        end
        @(posedge clk);
        #1;
        fb_m = r ? 2'b00 : e[1:0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        fb_m = 2'b00;
        // R7: after reset the held value is 00; invert exposes it as 11
        step(2'b11, 2'b10, 2'b01, 1'b0, 1'b0, "R7 reset state");
        // R1..R5, R8: exhaustive sweep with external operand
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 4; x++)
                for (int y = 0; y < 4; y++)
                    step(2'(s), 2'(x), 2'(y), 1'b1,  1'b0,
                         s == 3 ? "R1 invert" : s == 2 ? "R2 and" :
                         s == 1 ? "R3 or" : "R4 add");
        // R6: chained steps over every select and primary operand
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 4; x++)
                step(2'(s), 2'(x), 2'b00, 1'b0, 1'b0, "R6 chain");
        // R5 inside a chain, then R6 uses that step's result
        step(2'b01, 2'b00, 2'b10, 1'b1, 1'b0, "R5 inject");
        step(2'b00, 2'b01, 2'b11, 1'b0, 1'b0, "R6 after inject");
        step(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, "R6 invert chain");
        // R7 collides with a chained capture
        step(2'b00, 2'b11, 2'b00, 1'b1, 1'b0, "R5 preload");
        step(2'b01, 2'b10, 2'b00, 1'b0, 1'b1, "R7 comb path in reset");
        step(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, "R7 reset beats capture");
        // R8: change inputs inside one cycle without a clock edge
        @(negedge clk);
        op_sel = 2'b00; opa = 2'b11; opc = 2'b11; load = 1'b1;
        #1;
        checks++;
        if (res !== 3'b110) begin
            errors++;
            $display("FAIL R8 same-cycle: res=%b expected 110", res);
        end
        op_sel = 2'b10; opa = 2'b01;
        #1;
        checks++;
        if (res[1:0] !== 2'b01) begin
            errors++;
            $display("FAIL R8 same-cycle: res[1:0]=%b expected 01", res[1:0]);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule